// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block recovers asynchronous serial characters from a single receive line. A 16x oversampling enable, produced outside the block, paces its timing. A falling edge on the idle-high line opens a frame. The start bit is confirmed at its midpoint, and every later bit is read at the centre of its period. The data bits are assembled into a right-aligned word. An optional parity bit follows, then a single stop bit. At the stop-bit sample point the block delivers the word together with two error flags.

The receiver is configured through plain inputs:
- **Word width:** 7, 8 or 9 data bits.
- **Bit order:** the first data bit on the line is either the least or the most significant bit of the word.
- **Parity handling:** one of four modes.

These inputs are expected to stay constant while a frame is in flight.

The output side is a valid-only stream. The serial line cannot be paused, so there is no back-pressure and no ready input. The consumer must take the word in the single cycle in which `rx_valid` is high. A second word cannot appear sooner than one full frame later.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_data`, `rx_par_err` and `rx_frm_err` are all 0.
- R2: A low level that has gone high again by the 8th oversample tick after the falling edge is rejected as a false start. No word is delivered, and the receiver waits for the next falling edge.
- R3: `cfg_len` selects the data width: 0 gives 7 bits, 1 gives 8 bits, 2 gives 9 bits, and 3 is treated as 8 bits. The word is right-aligned in `rx_data` starting at bit 0, and unused upper bits read 0.
- R4: With `cfg_lsb_first` = 1, the first data bit received lands in bit 0. With `cfg_lsb_first` = 0, the first data bit lands in bit (width-1).
- R5: With `cfg_parity` = 00, no parity bit is expected, and the bit after the last data bit is taken as the stop bit.
- R6: With `cfg_parity` = 01, a parity bit is present and skipped, and `rx_par_err` is never set.
- R7: With `cfg_parity` = 10, `rx_par_err` is set when the data bits plus the parity bit contain an odd number of ones.
- R8: With `cfg_parity` = 11, `rx_par_err` is set when the data bits plus the parity bit contain an even number of ones.
- R9: A stop bit sampled low sets `rx_frm_err`, and the word is still delivered.
- R10: `rx_valid` is high for exactly one clock per frame. `rx_par_err` and `rx_frm_err` are meaningful in that cycle and are 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | 16x oversampling enable, one clock wide |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Data width select (0: 7, 1: 8, 2: 9, 3: 8) |
| cfg_lsb_first | input | 1 | 1: first bit is the LSB, 0: first bit is the MSB |
| cfg_parity | input | 2 | 00 none, 01 present and unchecked, 10 even, 11 odd |
| rx_valid | output | 1 | One-clock pulse marking a delivered word |
| rx_data | output | 9 | Received word, right-aligned |
| rx_par_err | output | 1 | Parity mismatch, qualified by `rx_valid` |
| rx_frm_err | output | 1 | Stop bit read low, qualified by `rx_valid` |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:

- **Short low glitch on the line.** A receiver that skips the mid-start check would report a phantom word.
- **Frames in both bit orders at every width.** An indexing slip would produce a mirrored word, or a word shifted by one place.
- **All four parity modes, with the parity bit flipped on purpose.** A swapped polarity, or a check that leaks into the unchecked mode, would raise `rx_par_err` on good frames or miss bad ones. Omitting the parity slot in mode 00 is included here: a design that got it wrong would read the stop bit one bit late.
- **Stop bit held low.** A design that drops the word on a framing error, or that fails to flag it, would show a missing word or a clear `rx_frm_err`.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_t;

  localparam int WORD_W = 9;

  function automatic logic [3:0] width_of(input logic [1:0] sel);
    case (sel)
      2'd0:    width_of = 4'd7;
      2'd2:    width_of = 4'd9;
      default: width_of = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/rxl_sync.sv
module rxl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign dout = chain[STAGES-1];
  assign fall = last & ~chain[STAGES-1];
endmodule

// File: rtl/rxl_tick_ctr.sv
module rxl_tick_ctr #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic half,
  input  logic tick_en,
  output logic sample
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] FULL_LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(OSR / 2 - 1);

  logic [CW-1:0] cnt;

  assign sample = tick_en && !hold && (cnt == (half ? HALF_LAST : FULL_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (hold)       cnt <= '0;
    else if (sample)     cnt <= '0;
    else if (tick_en)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rxl_word_build.sv
module rxl_word_build
  import rxl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              bit_we,
  input  logic              is_data,
  input  logic              bit_val,
  input  logic [3:0]        idx,
  input  logic [3:0]        nbits,
  input  logic              lsb_first,
  output logic [WORD_W-1:0] word,
  output logic              ones_odd
);
  logic [3:0] pos;

  assign pos = lsb_first ? idx : (nbits - 4'd1 - idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word     <= '0;
      ones_odd <= 1'b0;
    end else if (clear) begin
      word     <= '0;
      ones_odd <= 1'b0;
    end else if (bit_we) begin
      ones_odd <= ones_odd ^ bit_val;
      if (is_data && pos < 4'(WORD_W)) word[pos] <= bit_val;
    end
  end

  // R3
  clear_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (word == '0 && !ones_odd));
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import rxl_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              rx_line,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_lsb_first,
  input  logic [1:0]        cfg_parity,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_par_err,
  output logic              rx_frm_err
);
  rx_state_t         state;
  logic              line_s, line_fall, samp;
  logic [3:0]        idx, nbits;
  logic [WORD_W-1:0] word;
  logic              ones_odd;
  logic              start_ok, we, we_data;

  assign nbits    = width_of(cfg_len);
  assign start_ok = (state == ST_IDLE) && line_fall;
  assign we       = samp && (state == ST_DATA || state == ST_PAR);
  assign we_data  = (state == ST_DATA);

  rxl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s), .fall(line_fall)
  );

  rxl_tick_ctr #(.OSR(OSR)) u_ctr (
    .clk(clk), .rst_n(rst_n), .hold(state == ST_IDLE),
    .half(state == ST_START), .tick_en(tick_en), .sample(samp)
  );

  rxl_word_build u_build (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .bit_we(we),
    .is_data(we_data), .bit_val(line_s), .idx(idx), .nbits(nbits),
    .lsb_first(cfg_lsb_first), .word(word), .ones_odd(ones_odd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      idx        <= '0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
      case (state)
        ST_IDLE:  if (line_fall) state <= ST_START;
        ST_START: if (samp) begin
          idx   <= '0;
          state <= line_s ? ST_IDLE : ST_DATA;
        end
        ST_DATA:  if (samp) begin
          idx <= idx + 4'd1;
          if (idx == nbits - 4'd1)
            state <= (cfg_parity == 2'b00) ? ST_STOP : ST_PAR;
        end
        ST_PAR:   if (samp) state <= ST_STOP;
        ST_STOP:  if (samp) begin
          rx_valid   <= 1'b1;
          rx_data    <= word;
          rx_frm_err <= ~line_s;
          rx_par_err <= cfg_parity[1] & (ones_odd ^ cfg_parity[0]);
          state      <= ST_IDLE;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> (!rx_par_err && !rx_frm_err));

  // R6
  unchecked_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_parity[1]) |-> !rx_par_err);

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_len == 2'd0) |-> (rx_data[8:7] == 2'b00));

  // R2
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && samp && line_s) |=> (state == ST_IDLE));
endmodule

// File: tb/sim_serial_frame_rx.sv
module sim_serial_frame_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] cfg_len = 2'd1;
  logic       cfg_lsb_first = 1'b1;
  logic [1:0] cfg_parity = 2'b00;
  logic       rx_valid;
  logic [8:0] rx_data;
  logic       rx_par_err, rx_frm_err;

  int checks = 0, fails = 0;
  int got = 0;
  logic [8:0] cap_data;
  logic       cap_pe, cap_fe;
  int tdiv = 0;
  bit done = 0;

  serial_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rx_line(rx_line),
    .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first), .cfg_parity(cfg_parity),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
    tick_en <= (tdiv == 3);
  end

  always @(negedge clk) begin
    if (rx_valid) begin
      got      = got + 1;
      cap_data = rx_data;
      cap_pe   = rx_par_err;
      cap_fe   = rx_frm_err;
    end else if (rx_par_err || rx_frm_err) begin
      checks++; fails++;
      $display("FAIL R10: flag high without valid pe=%0b fe=%0b exp 0", rx_par_err, rx_frm_err);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] l);
    return (l == 2'd0) ? 7 : (l == 2'd2) ? 9 : 8;
  endfunction

  function automatic logic [8:0] mask_word(input logic [8:0] d, input int n);
    return d & 9'((1 << n) - 1);
  endfunction

  task automatic hold_bit(input logic v);
    rx_line = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic run_frame(input logic [8:0] d_in, input logic [1:0] len,
                           input logic lsb, input logic [1:0] par,
                           input bit flip_par, input bit bad_stop, input string tag);
    int n = width_of(len);
    logic [8:0] d = mask_word(d_in, n);
    logic pbit;
    cfg_len = len; cfg_lsb_first = lsb; cfg_parity = par;
    got = 0;
    hold_bit(1'b0);
    for (int i = 0; i < n; i++) hold_bit(lsb ? d[i] : d[n-1-i]);
    if (par != 2'b00) begin
      pbit = (par == 2'b11) ? ~(^d) : (par == 2'b10) ? (^d) : 1'($urandom);
      hold_bit(pbit ^ flip_par);
    end
    hold_bit(~bad_stop);
    rx_line = 1'b1;
    repeat (128) @(negedge clk);
    chk(got == 1, {tag, " R10 one valid"}, got, 1);
    chk(cap_data == d, {tag, " R3/R4 data"}, cap_data, d);
    chk(cap_pe == (par[1] && flip_par), {tag, " R7/R8 par_err"}, cap_pe, par[1] && flip_par);
    chk(cap_fe == bad_stop, {tag, " R9 frm_err"}, cap_fe, bad_stop);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!rx_valid && rx_data == 0 && !rx_par_err && !rx_frm_err, "R1 reset", rx_data, 0);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);

    // R2 glitch of 4 ticks
    got = 0;
    rx_line = 1'b0; repeat (16) @(negedge clk);
    rx_line = 1'b1; repeat (900) @(negedge clk);
    chk(got == 0, "R2 false start", got, 0);

    // directed corners
    run_frame(9'h1A5, 2'd2, 1'b1, 2'b00, 0, 0, "R3 9bit lsb");
    run_frame(9'h1A5, 2'd2, 1'b0, 2'b00, 0, 0, "R4 9bit msb");
    run_frame(9'h0C3, 2'd0, 1'b0, 2'b00, 0, 0, "R3 7bit upper zero");
    run_frame(9'h081, 2'd1, 1'b0, 2'b00, 0, 0, "R4 8bit msb");
    run_frame(9'h055, 2'd1, 1'b1, 2'b00, 0, 0, "R5 no parity");
    run_frame(9'h055, 2'd1, 1'b1, 2'b01, 1, 0, "R6 unchecked");
    run_frame(9'h013, 2'd1, 1'b1, 2'b10, 0, 0, "R7 even ok");
    run_frame(9'h013, 2'd1, 1'b1, 2'b10, 1, 0, "R7 even bad");
    run_frame(9'h013, 2'd1, 1'b1, 2'b11, 0, 0, "R8 odd ok");
    run_frame(9'h013, 2'd1, 1'b1, 2'b11, 1, 0, "R8 odd bad");
    run_frame(9'h0FF, 2'd3, 1'b1, 2'b00, 0, 1, "R9 bad stop");

    for (int k = 0; k < 40; k++) begin
      logic [1:0] l = 2'($urandom % 3);
      run_frame(9'($urandom), l, 1'($urandom), 2'($urandom),
                ($urandom % 4) == 0, ($urandom % 6) == 0, "rand");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule